// File: doc/BRIEF.md
# Two-Channel TCM Transfer Engine

This block copies blocks of 64-bit words between a tightly coupled memory (TCM) and an external memory reached through a request/response port. Two channels can be programmed, each with its own TCM word address, external word address, word count and direction. Only one channel runs at a time. The engine shares the single TCM port with the CPU and re-decides ownership every cycle. A CPU access always takes the port, and the engine simply waits in that cycle.

Software programs a channel through a plain write port: `cfg_sel` 0 = TCM start address, 1 = external start address, 2 = word count, 3 = direction (bit 0 of `cfg_wdata`; 0 copies TCM to external, 1 copies external to TCM). A start pulse queues the channel. The channel's live remaining count, busy, done and error flags are visible at all times. `irq` is high while any channel holds a done or error flag.

The external request channel follows valid/ready rules. Once `ext_req_valid` is raised, it stays high with the address, write flag and write data unchanged until the cycle in which `ext_req_ready` is sampled high. There is at most one request outstanding. Each request gets exactly one response on the response channel, taken in a cycle where `ext_rsp_valid` and `ext_rsp_ready` are both high. The engine raises `ext_rsp_ready` only while it waits for that response. A TCM read returns data one cycle after the access.

Top module: `tcm_xfer_engine`

## Requirements
- R1: After reset, all busy, done and error flags are 0, both remaining counts are 0, `irq` is 0, `ext_req_valid` is 0, and `tcm_en` is 0 while the CPU is idle.
- R2: A started channel copies exactly `count` words to consecutive increasing addresses. Direction 0 reads TCM and writes external memory; direction 1 does the opposite. The word just beyond the block is left unchanged.
- R3: At most one channel is busy in any cycle.
- R4: A start given to a channel while the other is busy is held pending and runs once the first finishes. If both channels are pending when the engine is free, channel 0 runs first.
- R5: In every cycle with `cpu_req` high, the TCM port carries the CPU's address, write flag and data. While the CPU holds the port, the engine makes no progress that needs the TCM.
- R6: A channel's remaining count (channel 0 in the low half of `stat_remain`) drops by exactly one for each word written to the destination, and never changes otherwise while the channel is busy.
- R7: On completion, the channel's done flag is set and stays set, with `irq` high, until a `clear` pulse for that channel.
- R8: An error response stops the channel. It clears busy, sets the error flag, raises `irq`, issues no further request, and keeps the remaining count at the words not yet written.
- R9: A raised `ext_req_valid` holds its payload stable until accepted.
- R10: A start is ignored when the channel's count is 0 or the channel is busy or pending. Configuration writes to a busy or pending channel are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_sel | input | 2 | Field select: 0 TCM addr, 1 ext addr, 2 count, 3 direction |
| cfg_wdata | input | CFG_W | Write data |
| start | input | 2 | Per-channel start pulse |
| clear | input | 2 | Per-channel done/error clear pulse |
| stat_busy | output | 2 | Channel running |
| stat_done | output | 2 | Channel completed (sticky) |
| stat_err | output | 2 | Channel stopped by error (sticky) |
| stat_remain | output | 2*LEN_W | Remaining counts, channel 0 low |
| irq | output | 1 | Any done or error flag set |
| cpu_req | input | 1 | CPU TCM access |
| cpu_we | input | 1 | CPU write |
| cpu_addr | input | TCM_AW | CPU word address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | TCM read data to CPU |
| tcm_en | output | 1 | TCM access enable |
| tcm_we | output | 1 | TCM write |
| tcm_addr | output | TCM_AW | TCM word address |
| tcm_wdata | output | DATA_W | TCM write data |
| tcm_rdata | input | DATA_W | TCM read data, one cycle after access |
| ext_req_valid | output | 1 | External request valid |
| ext_req_ready | input | 1 | External request accepted |
| ext_req_write | output | 1 | Request is a write |
| ext_req_addr | output | EXT_AW | External word address |
| ext_req_wdata | output | DATA_W | External write data |
| ext_rsp_valid | input | 1 | Response valid |
| ext_rsp_ready | output | 1 | Engine awaits a response |
| ext_rsp_rdata | input | DATA_W | Read response data |
| ext_rsp_err | input | 1 | Response carries an error |

## Verification
The bench builds the engine with a 6-bit TCM address, an 8-bit external address and a 4-bit count. With these widths the largest count, 15, fits in short runs. The whole TCM and external memory models can also be refilled and inspected word by word. The narrow count puts the full-length and single-word transfers, the error in mid-block and the exact remaining value after it all within a few hundred cycles. The same runs include CPU contention on alternate cycles and a stalling ready.

// File: rtl/tcm_xfer_pkg.sv
package tcm_xfer_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    CFG_TCM_ADDR = 2'd0,
    CFG_EXT_ADDR = 2'd1,
    CFG_COUNT    = 2'd2,
    CFG_DIR      = 2'd3
  } cfg_sel_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TCM_RD,
    SQ_TCM_CAP,
    SQ_EXT_REQ,
    SQ_EXT_RSP,
    SQ_TCM_WR
  } sq_state_e;

endpackage

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs
  import tcm_xfer_pkg::*;
#(
  parameter int TCM_AW = 12,
  parameter int EXT_AW = 29,
  parameter int LEN_W  = 16,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  cfg_sel_e          cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              start,
  input  logic              clear,
  input  logic              launch,
  input  logic              step,
  input  logic              fail,
  output logic [TCM_AW-1:0] tcm_addr,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [LEN_W-1:0]  remain,
  output logic              to_tcm,
  output logic              pending,
  output logic              busy,
  output logic              done,
  output logic              err
);

  logic locked;
  logic unused_cfg_bits;

  assign locked          = busy | pending;
  assign unused_cfg_bits = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcm_addr <= '0;
      ext_addr <= '0;
      remain   <= '0;
      to_tcm   <= 1'b0;
      pending  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (cfg_we && !locked) begin
        case (cfg_sel)
          CFG_TCM_ADDR: tcm_addr <= cfg_wdata[TCM_AW-1:0];
          CFG_EXT_ADDR: ext_addr <= cfg_wdata[EXT_AW-1:0];
          CFG_COUNT:    remain   <= cfg_wdata[LEN_W-1:0];
          default:      to_tcm   <= cfg_wdata[0];
        endcase
      end
      if (start && !locked && remain != '0) begin
        pending <= 1'b1;
        done    <= 1'b0;
        err     <= 1'b0;
      end
      if (clear) begin
        done <= 1'b0;
        err  <= 1'b0;
      end
      if (launch) begin
        pending <= 1'b0;
        busy    <= 1'b1;
      end
      if (step) begin
        remain   <= remain - 1'b1;
        tcm_addr <= tcm_addr + 1'b1;
        ext_addr <= ext_addr + 1'b1;
        if (remain == LEN_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (fail) begin
        busy <= 1'b0;
        err  <= 1'b1;
      end
    end
  end

  // R7: completion flag is sticky until cleared or restarted
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clear && !start) |=> done);

  // R6: while running, the count only holds or drops by one
  p_remain_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |->
      (remain == $past(remain) || remain == LEN_W'($past(remain) - 1'b1)));

endmodule

// File: rtl/tcm_port_arb.sv
module tcm_port_arb #(
  parameter int TCM_AW = 12,
  parameter int DATA_W = 64
) (
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [TCM_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [TCM_AW-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_gnt,
  output logic              tcm_en,
  output logic              tcm_we,
  output logic [TCM_AW-1:0] tcm_addr,
  output logic [DATA_W-1:0] tcm_wdata
);

  assign dma_gnt   = dma_req & ~cpu_req;
  assign tcm_en    = cpu_req | dma_req;
  assign tcm_we    = cpu_req ? cpu_we    : (dma_req & dma_we);
  assign tcm_addr  = cpu_req ? cpu_addr  : dma_addr;
  assign tcm_wdata = cpu_req ? cpu_wdata : dma_wdata;

endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import tcm_xfer_pkg::*;
#(
  parameter int TCM_AW = 12,
  parameter int EXT_AW = 29,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            pending,
  input  logic [NUM_CH-1:0][TCM_AW-1:0] ch_tcm_addr,
  input  logic [NUM_CH-1:0][EXT_AW-1:0] ch_ext_addr,
  input  logic [NUM_CH-1:0][LEN_W-1:0]  ch_remain,
  input  logic [NUM_CH-1:0]            ch_to_tcm,
  output logic [NUM_CH-1:0]            launch,
  output logic [NUM_CH-1:0]            step,
  output logic [NUM_CH-1:0]            fail,
  output logic                         dma_req,
  output logic                         dma_we,
  output logic [TCM_AW-1:0]            dma_addr,
  output logic [DATA_W-1:0]            dma_wdata,
  input  logic                         dma_gnt,
  input  logic [DATA_W-1:0]            tcm_rdata,
  output logic                         ext_req_valid,
  input  logic                         ext_req_ready,
  output logic                         ext_req_write,
  output logic [EXT_AW-1:0]            ext_req_addr,
  output logic [DATA_W-1:0]            ext_req_wdata,
  input  logic                         ext_rsp_valid,
  output logic                         ext_rsp_ready,
  input  logic [DATA_W-1:0]            ext_rsp_rdata,
  input  logic                         ext_rsp_err
);

  sq_state_e         state, nxt;
  logic              act, pick;
  logic [NUM_CH-1:0] act_oh;
  logic [DATA_W-1:0] hold_q;
  logic              last;
  logic              dir_in;

  assign pick   = ~pending[0];
  assign act_oh = act ? 2'b10 : 2'b01;
  assign last   = (ch_remain[act] == LEN_W'(1));
  assign dir_in = ch_to_tcm[act];

  assign dma_addr      = ch_tcm_addr[act];
  assign dma_wdata     = hold_q;
  assign ext_req_addr  = ch_ext_addr[act];
  assign ext_req_wdata = hold_q;
  assign ext_req_write = ~dir_in;

  always_comb begin
    nxt           = state;
    launch        = '0;
    step          = '0;
    fail          = '0;
    dma_req       = 1'b0;
    dma_we        = 1'b0;
    ext_req_valid = 1'b0;
    ext_rsp_ready = 1'b0;
    case (state)
      SQ_IDLE: begin
        if (|pending) begin
          launch = pick ? 2'b10 : 2'b01;
          nxt    = ch_to_tcm[pick] ? SQ_EXT_REQ : SQ_TCM_RD;
        end
      end
      SQ_TCM_RD: begin
        dma_req = 1'b1;
        if (dma_gnt) nxt = SQ_TCM_CAP;
      end
      SQ_TCM_CAP: nxt = SQ_EXT_REQ;
      SQ_EXT_REQ: begin
        ext_req_valid = 1'b1;
        if (ext_req_ready) nxt = SQ_EXT_RSP;
      end
      SQ_EXT_RSP: begin
        ext_rsp_ready = 1'b1;
        if (ext_rsp_valid) begin
          if (ext_rsp_err) begin
            fail = act_oh;
            nxt  = SQ_IDLE;
          end else if (dir_in) begin
            nxt = SQ_TCM_WR;
          end else begin
            step = act_oh;
            nxt  = last ? SQ_IDLE : SQ_TCM_RD;
          end
        end
      end
      SQ_TCM_WR: begin
        dma_req = 1'b1;
        dma_we  = 1'b1;
        if (dma_gnt) begin
          step = act_oh;
          nxt  = last ? SQ_IDLE : SQ_EXT_REQ;
        end
      end
      default: nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      act    <= 1'b0;
      hold_q <= '0;
    end else begin
      state <= nxt;
      if (state == SQ_IDLE && |pending) act <= pick;
      if (state == SQ_TCM_CAP) hold_q <= tcm_rdata;
      if (state == SQ_EXT_RSP && ext_rsp_valid && dir_in) hold_q <= ext_rsp_rdata;
    end
  end

  // R9: a stalled request keeps its payload
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_valid && !ext_req_ready) |=>
      (ext_req_valid && $stable(ext_req_addr) && $stable(ext_req_wdata)
       && $stable(ext_req_write)));

  // R5: a TCM request refused because of the CPU waits unchanged
  p_dma_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_gnt) |=> (dma_req && $stable(dma_addr) && $stable(dma_we)));

  // R8: an error response ends the run with no request after it
  p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rsp_valid && ext_rsp_ready && ext_rsp_err) |=> !ext_req_valid);

endmodule

// File: rtl/tcm_xfer_engine.sv
module tcm_xfer_engine
  import tcm_xfer_pkg::*;
#(
  parameter int TCM_AW = 12,
  parameter int EXT_AW = 29,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 64,
  parameter int CFG_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_ch,
  input  logic [1:0]              cfg_sel,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic [1:0]              start,
  input  logic [1:0]              clear,
  output logic [1:0]              stat_busy,
  output logic [1:0]              stat_done,
  output logic [1:0]              stat_err,
  output logic [2*LEN_W-1:0]      stat_remain,
  output logic                    irq,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [TCM_AW-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    tcm_en,
  output logic                    tcm_we,
  output logic [TCM_AW-1:0]       tcm_addr,
  output logic [DATA_W-1:0]       tcm_wdata,
  input  logic [DATA_W-1:0]       tcm_rdata,
  output logic                    ext_req_valid,
  input  logic                    ext_req_ready,
  output logic                    ext_req_write,
  output logic [EXT_AW-1:0]       ext_req_addr,
  output logic [DATA_W-1:0]       ext_req_wdata,
  input  logic                    ext_rsp_valid,
  output logic                    ext_rsp_ready,
  input  logic [DATA_W-1:0]       ext_rsp_rdata,
  input  logic                    ext_rsp_err
);

  logic [NUM_CH-1:0][TCM_AW-1:0] ch_tcm;
  logic [NUM_CH-1:0][EXT_AW-1:0] ch_ext;
  logic [NUM_CH-1:0][LEN_W-1:0]  ch_remain;
  logic [NUM_CH-1:0] ch_to_tcm, ch_pending, ch_busy, ch_done, ch_err;
  logic [NUM_CH-1:0] launch, step, fail;
  logic              dma_req, dma_we, dma_gnt;
  logic [TCM_AW-1:0] dma_addr;
  logic [DATA_W-1:0] dma_wdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    xfer_chan_regs #(
      .TCM_AW(TCM_AW), .EXT_AW(EXT_AW), .LEN_W(LEN_W), .CFG_W(CFG_W)
    ) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we && (cfg_ch == 1'(g))),
      .cfg_sel  (cfg_sel_e'(cfg_sel)),
      .cfg_wdata(cfg_wdata),
      .start    (start[g]),
      .clear    (clear[g]),
      .launch   (launch[g]),
      .step     (step[g]),
      .fail     (fail[g]),
      .tcm_addr (ch_tcm[g]),
      .ext_addr (ch_ext[g]),
      .remain   (ch_remain[g]),
      .to_tcm   (ch_to_tcm[g]),
      .pending  (ch_pending[g]),
      .busy     (ch_busy[g]),
      .done     (ch_done[g]),
      .err      (ch_err[g])
    );
  end

  xfer_sequencer #(
    .TCM_AW(TCM_AW), .EXT_AW(EXT_AW), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pending      (ch_pending),
    .ch_tcm_addr  (ch_tcm),
    .ch_ext_addr  (ch_ext),
    .ch_remain    (ch_remain),
    .ch_to_tcm    (ch_to_tcm),
    .launch       (launch),
    .step         (step),
    .fail         (fail),
    .dma_req      (dma_req),
    .dma_we       (dma_we),
    .dma_addr     (dma_addr),
    .dma_wdata    (dma_wdata),
    .dma_gnt      (dma_gnt),
    .tcm_rdata    (tcm_rdata),
    .ext_req_valid(ext_req_valid),
    .ext_req_ready(ext_req_ready),
    .ext_req_write(ext_req_write),
    .ext_req_addr (ext_req_addr),
    .ext_req_wdata(ext_req_wdata),
    .ext_rsp_valid(ext_rsp_valid),
    .ext_rsp_ready(ext_rsp_ready),
    .ext_rsp_rdata(ext_rsp_rdata),
    .ext_rsp_err  (ext_rsp_err)
  );

  tcm_port_arb #(.TCM_AW(TCM_AW), .DATA_W(DATA_W)) arb_i (
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .dma_req  (dma_req),
    .dma_we   (dma_we),
    .dma_addr (dma_addr),
    .dma_wdata(dma_wdata),
    .dma_gnt  (dma_gnt),
    .tcm_en   (tcm_en),
    .tcm_we   (tcm_we),
    .tcm_addr (tcm_addr),
    .tcm_wdata(tcm_wdata)
  );

  assign cpu_rdata   = tcm_rdata;
  assign stat_busy   = ch_busy;
  assign stat_done   = ch_done;
  assign stat_err    = ch_err;
  assign stat_remain = ch_remain;
  assign irq         = |(ch_done | ch_err);

  // R3: channels never run together
  p_one_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_busy));

endmodule

// File: tb/tcm_xfer_engine_tb_top.sv
module tcm_xfer_engine_tb_top;

  localparam int TAW = 6;
  localparam int EAW = 8;
  localparam int LW  = 4;
  localparam int DW  = 64;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_we = 0, cfg_ch = 0;
  logic [1:0]    cfg_sel = 0;
  logic [CW-1:0] cfg_wdata = 0;
  logic [1:0]    start = 0, clear = 0;
  logic [1:0]    stat_busy, stat_done, stat_err;
  logic [2*LW-1:0] stat_remain;
  logic          irq;
  logic          cpu_req, cpu_we;
  logic [TAW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          tcm_en, tcm_we;
  logic [TAW-1:0] tcm_addr;
  logic [DW-1:0] tcm_wdata;
  logic [DW-1:0] tcm_rdata;
  logic          ext_req_valid, ext_req_ready, ext_req_write;
  logic [EAW-1:0] ext_req_addr;
  logic [DW-1:0] ext_req_wdata;
  logic          ext_rsp_valid, ext_rsp_ready, ext_rsp_err;
  logic [DW-1:0] ext_rsp_rdata;

  logic       cpu_noise = 0, cpu_hold = 0, ext_stall = 0, fill = 0;
  logic       err_en = 0;
  logic [EAW-1:0] err_addr = '0;
  logic [15:0] cyc;

  assign cpu_req       = cpu_noise ? cyc[1] : cpu_hold;
  assign cpu_we        = 1'b0;
  assign cpu_addr      = '1;
  assign cpu_wdata     = '0;
  assign ext_req_ready = ext_stall ? (cyc[1:0] == 2'b11) : 1'b1;

  tcm_xfer_engine #(.TCM_AW(TAW), .EXT_AW(EAW), .LEN_W(LW), .DATA_W(DW), .CFG_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .clear(clear), .stat_busy(stat_busy),
    .stat_done(stat_done), .stat_err(stat_err), .stat_remain(stat_remain), .irq(irq),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .tcm_en(tcm_en), .tcm_we(tcm_we), .tcm_addr(tcm_addr),
    .tcm_wdata(tcm_wdata), .tcm_rdata(tcm_rdata), .ext_req_valid(ext_req_valid),
    .ext_req_ready(ext_req_ready), .ext_req_write(ext_req_write),
    .ext_req_addr(ext_req_addr), .ext_req_wdata(ext_req_wdata),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_ready(ext_rsp_ready),
    .ext_rsp_rdata(ext_rsp_rdata), .ext_rsp_err(ext_rsp_err));

  function automatic logic [DW-1:0] tpat(input int i);
    return {32'h7C00_0000 + 32'(i), ~32'(i)};
  endfunction
  function automatic logic [DW-1:0] epat(input int j);
    return {32'hE000_0000 + 32'(j), 32'h1234_5678 ^ 32'(j)};
  endfunction

  // memory models
  logic [DW-1:0] tmem [64];
  logic [DW-1:0] emem [256];

  always @(posedge clk) begin
    cyc <= rst_n ? cyc + 16'd1 : 16'd0;
    if (fill) begin
      for (int i = 0; i < 64; i++)  tmem[i] <= tpat(i);
      for (int j = 0; j < 256; j++) emem[j] <= epat(j);
    end else begin
      if (tcm_en) begin
        if (tcm_we) tmem[tcm_addr] <= tcm_wdata;
        else        tcm_rdata <= tmem[tcm_addr];
      end
      if (ext_req_valid && ext_req_ready && ext_req_write)
        emem[ext_req_addr] <= ext_req_wdata;
    end
    if (!rst_n) begin
      ext_rsp_valid <= 1'b0;
      ext_rsp_err   <= 1'b0;
      ext_rsp_rdata <= '0;
    end else if (ext_req_valid && ext_req_ready) begin
      ext_rsp_valid <= 1'b1;
      ext_rsp_rdata <= emem[ext_req_addr];
      ext_rsp_err   <= err_en && (ext_req_addr == err_addr);
    end else if (ext_rsp_valid && ext_rsp_ready) begin
      ext_rsp_valid <= 1'b0;
    end
  end

  int n_tests = 0, n_fail = 0;
  int bad_r5 = 0, bad_r6 = 0, bad_r9 = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // port monitors
  logic [1:0]    p_busy;
  logic [2*LW-1:0] p_rem;
  logic          p_vld, p_rdy, p_wr;
  logic [EAW-1:0] p_addr;
  logic [DW-1:0] p_wd;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_req && !(tcm_en && !tcm_we && tcm_addr == cpu_addr)) bad_r5++;
      for (int c = 0; c < 2; c++)
        if (p_busy[c] && stat_busy[c] && stat_remain[c*LW +: LW] != p_rem[c*LW +: LW]
            && stat_remain[c*LW +: LW] != p_rem[c*LW +: LW] - 4'd1) bad_r6++;
      if (p_vld && !p_rdy && !(ext_req_valid && ext_req_addr == p_addr
          && ext_req_wdata == p_wd && ext_req_write == p_wr)) bad_r9++;
    end
    p_busy = stat_busy; p_rem = stat_remain; p_vld = ext_req_valid;
    p_rdy = ext_req_ready; p_addr = ext_req_addr; p_wd = ext_req_wdata; p_wr = ext_req_write;
  end

  task automatic cfg_write(input logic ch, input logic [1:0] sel, input int val);
    cfg_we = 1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = CW'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic prog(input logic ch, input logic dir, input int t, input int e, input int len);
    cfg_write(ch, 2'd0, t);
    cfg_write(ch, 2'd1, e);
    cfg_write(ch, 2'd2, len);
    cfg_write(ch, 2'd3, int'(dir));
  endtask

  task automatic pulse_start(input logic [1:0] m);
    start = m; @(negedge clk); start = 0;
  endtask
  task automatic pulse_clear(input logic [1:0] m);
    clear = m; @(negedge clk); clear = 0;
  endtask
  task automatic refill;
    fill = 1; @(negedge clk); fill = 0;
  endtask
  task automatic wait_flag(input int ch);
    for (int k = 0; k < 3000; k++) begin
      if (stat_done[ch] || stat_err[ch]) break;
      @(negedge clk);
    end
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk_block(input string tag, input logic dir, input int t, input int e, input int len);
    for (int k = 0; k < len; k++) begin
      if (dir) chk(tag, tmem[t+k], epat(e+k));
      else     chk(tag, emem[e+k], tpat(t+k));
    end
    if (dir) chk({tag, " edge"}, tmem[t+len], tpat(t+len));
    else     chk({tag, " edge"}, emem[e+len], epat(e+len));
  endtask

  // {ch, dir, tcm, ext, len, cpu contention, ext stall}
  localparam logic [21:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd0,  8'h10, 4'd4,  1'b0, 1'b0},
    {1'b1, 1'b1, 6'd8,  8'h20, 4'd7,  1'b0, 1'b1},
    {1'b0, 1'b1, 6'd16, 8'h30, 4'd15, 1'b1, 1'b0},
    {1'b1, 1'b0, 6'd33, 8'h50, 4'd1,  1'b1, 1'b1},
    {1'b0, 1'b0, 6'd40, 8'h60, 4'd15, 1'b1, 1'b1},
    {1'b1, 1'b1, 6'd48, 8'h80, 4'd9,  1'b0, 1'b0}
  };

  initial begin
    logic [LW-1:0] ra, rb;
    idle(3);
    refill();
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", 64'(stat_busy), 64'd0);
    chk("R1 done/err", 64'({stat_done, stat_err}), 64'd0);
    chk("R1 remain", 64'(stat_remain), 64'd0);
    chk("R1 irq/req/tcm_en", 64'({irq, ext_req_valid, tcm_en}), 64'd0);

    // R2/R6/R7: table walk
    for (int v = 0; v < 6; v++) begin
      logic ch, dir;
      int t, e, len;
      ch = VEC[v][21]; dir = VEC[v][20]; t = int'(VEC[v][19:14]);
      e = int'(VEC[v][13:6]); len = int'(VEC[v][5:2]);
      refill();
      cpu_noise = VEC[v][1]; ext_stall = VEC[v][0];
      prog(ch, dir, t, e, len);
      pulse_start(ch ? 2'b10 : 2'b01);
      wait_flag(int'(ch));
      cpu_noise = 0; ext_stall = 0;
      idle(4);
      chk_block($sformatf("R2 vec%0d", v), dir, t, e, len);
      chk($sformatf("R6 vec%0d remain", v), 64'(stat_remain[int'(ch)*LW +: LW]), 64'd0);
      chk($sformatf("R7 vec%0d done sticky", v), 64'({stat_done[ch], stat_err[ch], stat_busy[ch], irq}), 64'b1001);
      pulse_clear(ch ? 2'b10 : 2'b01);
      chk($sformatf("R7 vec%0d clear", v), 64'({stat_done, irq}), 64'd0);
    end

    // R4: start on channel 1 while channel 0 runs
    refill();
    prog(1'b0, 1'b0, 2, 8'h40, 10);
    prog(1'b1, 1'b1, 30, 8'h90, 3);
    pulse_start(2'b01);
    idle(3);
    pulse_start(2'b10);
    idle(6);
    chk("R4 second waits", 64'(stat_busy), 64'b01);
    wait_flag(0);
    idle(2);
    chk("R4 second runs after", 64'({stat_busy[1] | stat_done[1]}), 64'd1);
    wait_flag(1);
    idle(2);
    chk_block("R4 ch0 data", 1'b0, 2, 8'h40, 10);
    chk_block("R4 ch1 data", 1'b1, 30, 8'h90, 3);
    pulse_clear(2'b11);

    // R4: both pending together, channel 0 first
    prog(1'b0, 1'b1, 4, 8'hA0, 3);
    prog(1'b1, 1'b1, 12, 8'hB0, 3);
    pulse_start(2'b11);
    for (int k = 0; k < 20; k++) begin
      if (stat_busy != 2'b00) break;
      @(negedge clk);
    end
    chk("R4 order ch0 first", 64'(stat_busy), 64'b01);
    wait_flag(1);
    idle(2);
    chk("R4 both done", 64'(stat_done), 64'b11);
    pulse_clear(2'b11);

    // R5: CPU holds the port, engine stalls
    refill();
    prog(1'b0, 1'b1, 20, 8'hC0, 12);
    pulse_start(2'b01);
    idle(6);
    cpu_hold = 1;
    idle(8);
    ra = stat_remain[LW-1:0];
    idle(6);
    rb = stat_remain[LW-1:0];
    cpu_hold = 0;
    chk("R5 stalled under cpu", 64'(rb), 64'(ra));
    chk("R5 still busy", 64'(stat_busy), 64'b01);
    wait_flag(0);
    idle(2);
    chk_block("R5 data after stall", 1'b1, 20, 8'hC0, 12);
    pulse_clear(2'b01);

    // R8: error in mid-block
    refill();
    err_en = 1; err_addr = 8'h45;
    prog(1'b1, 1'b1, 20, 8'h43, 6);
    pulse_start(2'b10);
    wait_flag(1);
    idle(3);
    chk("R8 err flags", 64'({stat_err[1], stat_done[1], stat_busy[1], irq}), 64'b1001);
    chk("R8 remain", 64'(stat_remain[2*LW-1:LW]), 64'd4);
    chk("R8 no request", 64'(ext_req_valid), 64'd0);
    chk("R8 words before", tmem[21], epat(8'h44));
    chk("R8 failed word untouched", tmem[22], tpat(22));
    err_en = 0;
    pulse_clear(2'b10);
    chk("R7 clear err", 64'(irq), 64'd0);

    // R10: zero count start ignored
    prog(1'b0, 1'b0, 0, 0, 0);
    pulse_start(2'b01);
    idle(10);
    chk("R10 zero count", 64'({stat_busy, stat_done, ext_req_valid}), 64'd0);

    // R10: config write while busy ignored, restart ignored
    refill();
    prog(1'b1, 1'b0, 10, 8'h70, 8);
    pulse_start(2'b10);
    idle(4);
    cfg_write(1'b1, 2'd2, 1);
    cfg_write(1'b1, 2'd0, 50);
    pulse_start(2'b10);
    wait_flag(1);
    idle(2);
    chk_block("R10 locked config", 1'b0, 10, 8'h70, 8);
    chk("R10 single run", 64'(stat_busy), 64'd0);
    pulse_clear(2'b10);

    chk("R5 monitor cpu owns port", 64'(bad_r5), 64'd0);
    chk("R6 monitor count steps", 64'(bad_r6), 64'd0);
    chk("R9 monitor payload hold", 64'(bad_r9), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule